// File: doc/BRIEF.md
# Ping-Pong DMA Word Address Generator

This block produces the word address that an internal DMA engine uses while it moves FIFO data to or from system memory. Firmware programs an enable, a mode (single buffer or double buffer), a buffer length and two base addresses. It then starts a transfer, and the engine reports every finished word on a one-cycle handshake. In single-buffer mode the address walks upward from base 0 for as long as the transfer runs. In double-buffer mode the block counts the words of the current buffer. When the buffer is full it raises a one-cycle completion pulse, flips the active-buffer indicator and continues from the start of the other buffer.

The buffer length is programmed in units of eight 32-bit words. While a double-buffer transfer runs, firmware refills the buffer that is not in use and moves its base address to the next memory region. The block protects the buffer in use: a base write aimed at the active buffer is dropped. The mode, enable and length settings are locked while a transfer is running.

Top module: `dbufAddrGen`

## Requirements
- R1: After reset, busy, the active-buffer indicator, the completion pulse, the current address, both base registers and the three configuration fields all read 0.
- R2: A base register stores bits [31:2] of the written value, and its bits [1:0] always read 0.
- R3: A start request is accepted only while idle and enabled, and it is refused in double mode when the length field is 0. An accepted start sets busy, selects buffer 0 (indicator 0) and loads the current address from base 0 on the next edge.
- R4: Each word handshake while busy advances the current address by 4, unless that word closes a double-mode buffer.
- R5: In single mode the address continues linearly from base 0 with no buffer limit, the indicator stays 0 and no completion pulse occurs.
- R6: In double mode with length field N, the 8*N-th word of a buffer produces a one-cycle completion pulse. In that same cycle the indicator toggles (0 means buffer 0, 1 means buffer 1) and the address reloads from the base of the newly active buffer, so N=1 gives 8 words per buffer.
- R7: While busy, a write to base 0 takes effect only when the indicator is 1, and a write to base 1 only when it is 0. A write to the active buffer's base is dropped. Both bases are writable while idle.
- R8: Writes to the enable, mode and length fields are ignored while busy.
- R9: A stop request ends the transfer and leaves the address and the indicator unchanged. When a stop and a word handshake arrive in the same cycle, the stop wins and the address does not advance.
- R10: When a permitted write to the inactive base and the buffer-closing word arrive in the same cycle, the reload uses the newly written base value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for enable, mode and length |
| cfgEnIn | input | 1 | Enable value to write |
| cfgDblIn | input | 1 | Mode value to write (1 = double buffer) |
| cfgSizeIn | input | 8 | Buffer length value to write, in units of 8 words |
| base0WrEn | input | 1 | Write strobe for base 0 |
| base0WrData | input | 32 | Base 0 write data |
| base1WrEn | input | 1 | Write strobe for base 1 |
| base1WrData | input | 32 | Base 1 write data |
| xferStart | input | 1 | Start request |
| xferStop | input | 1 | Stop request |
| wordDone | input | 1 | One word has been transferred |
| busy | output | 1 | Transfer running |
| curAddr | output | 32 | Current word address |
| activeBuf | output | 1 | Active buffer indicator |
| bufDone | output | 1 | One-cycle buffer completion pulse |
| base0Q | output | 32 | Base 0 readback |
| base1Q | output | 32 | Base 1 readback |
| cfgEnQ | output | 1 | Enable readback |
| cfgDblQ | output | 1 | Mode readback |
| cfgSizeQ | output | 8 | Length readback |

## Verification
The main concurrency case puts a firmware base write and a buffer switch in the same cycle. The bench issues a write to the inactive base together with the word handshake that closes the buffer. It then checks that the reloaded address equals the newly written value and that the completion pulse and the indicator flip appear on the same edge. A second collision pairs a stop request with a word handshake, and the bench checks that the address stays put. The other checks sweep buffer lengths of 1 to 3 units across three consecutive buffers. The expected address, indicator and pulse for every word are computed from the word index.

// File: rtl/dbufPkg.sv
package dbufPkg;
  // Strobes from the control to the address datapath
  typedef struct packed {
    logic startLoad;   // load curAddr from base 0
    logic advance;     // curAddr += 4
    logic switchBuf;   // reload curAddr from the base selected by switchTo
    logic switchTo;    // buffer that becomes active
    logic wrBase0;     // accepted write of base 0
    logic wrBase1;     // accepted write of base 1
  } dpCtl_t;
endpackage

// File: rtl/dbufCtl.sv
module dbufCtl
  import dbufPkg::*;
#(
  parameter int SIZE_W    = 8,
  parameter int UNIT_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgEnIn,
  input  logic              cfgDblIn,
  input  logic [SIZE_W-1:0] cfgSizeIn,
  input  logic              base0WrEn,
  input  logic              base1WrEn,
  input  logic              xferStart,
  input  logic              xferStop,
  input  logic              wordDone,
  output dpCtl_t            ctl,
  output logic              busy,
  output logic              activeBuf,
  output logic              bufDone,
  output logic              cfgEnQ,
  output logic              cfgDblQ,
  output logic [SIZE_W-1:0] cfgSizeQ
);
  localparam int CNT_W = SIZE_W + UNIT_LOG2;

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] bufWords;
  logic             lastWord;
  logic             startOk;
  logic             stepOk;

  assign bufWords = {cfgSizeQ, {UNIT_LOG2{1'b0}}};
  assign lastWord = (wordCnt == bufWords - CNT_W'(1));
  assign startOk  = xferStart && !busy && cfgEnQ &&
                    !(cfgDblQ && (cfgSizeQ == '0));
  assign stepOk   = busy && wordDone && !xferStop;

  always_comb begin
    ctl           = '0;
    ctl.startLoad = startOk;
    ctl.wrBase0   = base0WrEn && (!busy || activeBuf);
    ctl.wrBase1   = base1WrEn && (!busy || !activeBuf);
    if (stepOk) begin
      if (cfgDblQ && lastWord) begin
        ctl.switchBuf = 1'b1;
        ctl.switchTo  = !activeBuf;
      end else begin
        ctl.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnQ   <= 1'b0;
      cfgDblQ  <= 1'b0;
      cfgSizeQ <= '0;
    end else if (cfgWrEn && !busy) begin
      cfgEnQ   <= cfgEnIn;
      cfgDblQ  <= cfgDblIn;
      cfgSizeQ <= cfgSizeIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      activeBuf <= 1'b0;
      bufDone   <= 1'b0;
      wordCnt   <= '0;
    end else begin
      bufDone <= 1'b0;
      if (startOk) begin
        busy      <= 1'b1;
        activeBuf <= 1'b0;
        wordCnt   <= '0;
      end else if (busy && xferStop) begin
        busy <= 1'b0;
      end else if (stepOk && cfgDblQ) begin
        if (lastWord) begin
          wordCnt   <= '0;
          activeBuf <= !activeBuf;
          bufDone   <= 1'b1;
        end else begin
          wordCnt <= wordCnt + CNT_W'(1);
        end
      end
    end
  end

  // R5: completion pulses only appear in double mode
  p_done_dbl_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufDone |-> cfgDblQ);

  // R6: each completion pulse comes with a flip of the indicator
  p_toggle_on_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufDone |-> (activeBuf != $past(activeBuf)));

  // R8: the length setting is frozen while a transfer runs
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> ($stable(cfgSizeQ) && $stable(cfgDblQ) && $stable(cfgEnQ)));

  // R9: a stop request always leaves the block idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferStop) |=> !busy);
endmodule

// File: rtl/dbufDp.sv
module dbufDp
  import dbufPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] base0WrData,
  input  logic [ADDR_W-1:0] base1WrData,
  output logic [ADDR_W-1:0] base0Q,
  output logic [ADDR_W-1:0] base1Q,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int ALIGN_W = 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  logic [ADDR_W-1:0] wr0Aligned;
  logic [ADDR_W-1:0] wr1Aligned;
  logic [ADDR_W-1:0] eff0;
  logic [ADDR_W-1:0] eff1;

  assign wr0Aligned = {base0WrData[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign wr1Aligned = {base1WrData[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  // Same-cycle bypass so a reload sees a base written on that edge
  assign eff0 = ctl.wrBase0 ? wr0Aligned : base0Q;
  assign eff1 = ctl.wrBase1 ? wr1Aligned : base1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base0Q  <= '0;
      base1Q  <= '0;
      curAddr <= '0;
    end else begin
      base0Q <= eff0;
      base1Q <= eff1;
      if (ctl.startLoad)      curAddr <= eff0;
      else if (ctl.switchBuf) curAddr <= ctl.switchTo ? eff1 : eff0;
      else if (ctl.advance)   curAddr <= curAddr + STEP;
    end
  end

  // R4: one word step moves the address by exactly one word
  p_word_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.advance) |-> (curAddr == $past(curAddr) + STEP));

  // R10: a reload lands on the base register value now stored
  p_reload_base_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.switchBuf) |-> (curAddr == ($past(ctl.switchTo) ? base1Q : base0Q)));
endmodule

// File: rtl/dbufAddrGen.sv
module dbufAddrGen
  import dbufPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 8,
  parameter int UNIT_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgEnIn,
  input  logic              cfgDblIn,
  input  logic [SIZE_W-1:0] cfgSizeIn,
  input  logic              base0WrEn,
  input  logic [ADDR_W-1:0] base0WrData,
  input  logic              base1WrEn,
  input  logic [ADDR_W-1:0] base1WrData,
  input  logic              xferStart,
  input  logic              xferStop,
  input  logic              wordDone,
  output logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic              activeBuf,
  output logic              bufDone,
  output logic [ADDR_W-1:0] base0Q,
  output logic [ADDR_W-1:0] base1Q,
  output logic              cfgEnQ,
  output logic              cfgDblQ,
  output logic [SIZE_W-1:0] cfgSizeQ
);
  dpCtl_t ctl;

  dbufCtl #(.SIZE_W(SIZE_W), .UNIT_LOG2(UNIT_LOG2)) uCtl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgEnIn(cfgEnIn), .cfgDblIn(cfgDblIn), .cfgSizeIn(cfgSizeIn),
    .base0WrEn(base0WrEn), .base1WrEn(base1WrEn),
    .xferStart(xferStart), .xferStop(xferStop), .wordDone(wordDone),
    .ctl(ctl), .busy(busy), .activeBuf(activeBuf), .bufDone(bufDone),
    .cfgEnQ(cfgEnQ), .cfgDblQ(cfgDblQ), .cfgSizeQ(cfgSizeQ)
  );

  dbufDp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .base0WrData(base0WrData), .base1WrData(base1WrData),
    .base0Q(base0Q), .base1Q(base1Q), .curAddr(curAddr)
  );

  // R7: the base of the buffer in use cannot change during a transfer
  p_base0_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !$past(activeBuf)) |-> $stable(base0Q));
  p_base1_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && $past(activeBuf)) |-> $stable(base1Q));
endmodule

// File: tb/tb_dbufAddrGen.sv
module tb_dbufAddrGen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 0, cfgEnIn = 0, cfgDblIn = 0;
  logic [7:0]  cfgSizeIn = 0;
  logic        base0WrEn = 0, base1WrEn = 0;
  logic [31:0] base0WrData = 0, base1WrData = 0;
  logic        xferStart = 0, xferStop = 0, wordDone = 0;
  logic        busy, activeBuf, bufDone, cfgEnQ, cfgDblQ;
  logic [31:0] curAddr, base0Q, base1Q;
  logic [7:0]  cfgSizeQ;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbufAddrGen dut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgEnIn(cfgEnIn), .cfgDblIn(cfgDblIn), .cfgSizeIn(cfgSizeIn),
    .base0WrEn(base0WrEn), .base0WrData(base0WrData),
    .base1WrEn(base1WrEn), .base1WrData(base1WrData),
    .xferStart(xferStart), .xferStop(xferStop), .wordDone(wordDone),
    .busy(busy), .curAddr(curAddr), .activeBuf(activeBuf), .bufDone(bufDone),
    .base0Q(base0Q), .base1Q(base1Q),
    .cfgEnQ(cfgEnQ), .cfgDblQ(cfgDblQ), .cfgSizeQ(cfgSizeQ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cfgWrEn = 0; base0WrEn = 0; base1WrEn = 0;
    xferStart = 0; xferStop = 0; wordDone = 0;
  endtask

  task automatic setCfg(input logic en, input logic dbl, input logic [7:0] sz);
    cfgWrEn = 1; cfgEnIn = en; cfgDblIn = dbl; cfgSizeIn = sz;
    step();
  endtask

  task automatic setBases(input logic [31:0] b0, input logic [31:0] b1);
    base0WrEn = 1; base0WrData = b0; base1WrEn = 1; base1WrData = b1;
    step();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 activeBuf", {31'd0, activeBuf}, 0);
    chk("R1 bufDone", {31'd0, bufDone}, 0);
    chk("R1 curAddr", curAddr, 0);
    chk("R1 base0", base0Q, 0);
    chk("R1 base1", base1Q, 0);
    chk("R1 cfg", {22'd0, cfgEnQ, cfgDblQ, cfgSizeQ}, 0);

    // R2 low bits dropped
    setBases(32'h0000_1003, 32'h0000_2002);
    chk("R2 base0", base0Q, 32'h0000_1000);
    chk("R2 base1", base1Q, 32'h0000_2000);

    // R3 refused while disabled
    xferStart = 1; step();
    chk("R3 disabled start", {31'd0, busy}, 0);
    // R3 refused in double mode with length 0
    setCfg(1, 1, 0);
    xferStart = 1; step();
    chk("R3 zero length start", {31'd0, busy}, 0);

    // R4/R6 sweep over lengths 1..3, three buffers each
    for (int s = 1; s <= 3; s++) begin
      logic [31:0] b0, b1, expA;
      int len;
      b0 = 32'h1000 * s;
      b1 = 32'h8000 + 32'h100 * s;
      len = 8 * s;
      setCfg(1, 1, 8'(s));
      setBases(b0, b1);
      xferStart = 1; step();
      chk("R3 start busy", {31'd0, busy}, 1);
      chk("R3 start addr", curAddr, b0);
      chk("R3 start buffer", {31'd0, activeBuf}, 0);
      for (int k = 1; k <= 3 * len; k++) begin
        int bufIdx;
        wordDone = 1; step();
        bufIdx = (k / len) % 2;
        expA = (bufIdx == 1 ? b1 : b0) + 32'(4 * (k % len));
        chk("R4 R6 addr", curAddr, expA);
        chk("R6 buffer", {31'd0, activeBuf}, 32'(bufIdx));
        chk("R6 pulse", {31'd0, bufDone}, (k % len == 0) ? 1 : 0);
      end
      xferStop = 1; step();
      chk("R9 stop", {31'd0, busy}, 0);
    end

    // R10 collision of inactive base write with buffer switch
    setCfg(1, 1, 1);
    setBases(32'h1000, 32'h2000);
    xferStart = 1; step();
    for (int k = 0; k < 7; k++) begin
      wordDone = 1; step();
    end
    chk("R4 pre-switch addr", curAddr, 32'h1000 + 32'd28);
    wordDone = 1; base1WrEn = 1; base1WrData = 32'h3000; step();
    chk("R10 reload addr", curAddr, 32'h3000);
    chk("R10 pulse", {31'd0, bufDone}, 1);
    chk("R10 buffer", {31'd0, activeBuf}, 1);
    step();
    chk("R6 pulse one cycle", {31'd0, bufDone}, 0);

    // R7 active base write dropped, inactive accepted
    base1WrEn = 1; base1WrData = 32'h4000; step();
    chk("R7 active base kept", base1Q, 32'h3000);
    base0WrEn = 1; base0WrData = 32'h5000; step();
    chk("R7 inactive base written", base0Q, 32'h5000);

    // R8 configuration frozen while busy
    setCfg(0, 0, 5);
    chk("R8 size kept", {24'd0, cfgSizeQ}, 1);
    chk("R8 mode kept", {30'd0, cfgEnQ, cfgDblQ}, 3);

    // R9 stop beats word handshake
    wordDone = 1; xferStop = 1; step();
    chk("R9 addr held", curAddr, 32'h3000);
    chk("R9 idle", {31'd0, busy}, 0);
    chk("R9 buffer held", {31'd0, activeBuf}, 1);

    // R5 single mode runs past the buffer length
    setCfg(1, 0, 1);
    setBases(32'h0000_7000, 32'h0000_9000);
    xferStart = 1; step();
    chk("R5 start addr", curAddr, 32'h7000);
    for (int k = 1; k <= 20; k++) begin
      wordDone = 1; step();
      chk("R5 addr", curAddr, 32'h7000 + 32'(4 * k));
      chk("R5 buffer", {31'd0, activeBuf}, 0);
      chk("R5 no pulse", {31'd0, bufDone}, 0);
    end
    xferStop = 1; step();
    finishRun();
  end
endmodule